// File: doc/BRIEF.md
# Indirect Video Memory Access Port

This block gives a CPU access to a 64K-word video memory through a small window of three registers instead of a direct mapping. The CPU writes a pointer register to choose a word, then moves data through a data register that steps the pointer by a programmable stride after each store. Reads never touch memory directly. They return a buffer that the block refills in the background whenever the pointer changes. A fixed, parameterised latency models the memory access time, and a `vid_busy` input stands for the video side holding the memory, which defers every CPU-side memory cycle.

The 16-bit address space is split in two halves. Pointer values with bit 15 clear select the main RAM. Values with bit 15 set select a smaller attribute RAM. Each RAM is mirrored across its half when it is smaller than 32K words. The stride is added only within the low 15 bits, so each half wraps onto itself. The CPU bus carries a 16-bit word, a two-bit register offset, and two byte strobes: `cpu_be[1]` is the even (upper) lane and `cpu_be[0]` is the odd (lower) lane.

Register offsets on `cpu_reg`: 0 = pointer (write) / buffer (read), 1 = data, 2 = stride, 3 = unused (reads zero, writes dropped).

Top module: `vram_port`

## Requirements
- R1: Reset (synchronous, active high) clears the pointer, the stride, the read buffer and `cpu_rdata` to 0x0000.
- R2: A write to offset 0 loads the pointer, then fetches the word at that pointer into the read buffer. The new buffer value is visible to a read issued 2+PF_LAT cycles after the write, or later, while `vid_busy` stays low.
- R3: A write to offset 1 stores the word at the current pointer, advances the pointer by the stride, then prefetches the word at the new pointer into the buffer.
- R4: The advance adds stride bits 14..0 to pointer bits 14..0 and leaves pointer bit 15 unchanged, so 0x7FFF steps to 0x0000 and 0xFFFF steps to 0x8000. Stride bit 15 has no effect, and a stride of 0x7FFF steps by -1.
- R5: A read of offset 1 or offset 0 returns the read buffer and leaves the pointer unchanged. A read of offset 2 returns all 16 stride bits as last written.
- R6: A write with `cpu_be`=2'b10 copies `cpu_wdata[15:8]` into both bytes of the target register or stored word. A write with `cpu_be`=2'b01 is dropped entirely: nothing is stored, the pointer does not step and no register changes.
- R7: A read with `cpu_be`=2'b10 returns the upper byte of the selected value on bits 15..8 and zero on bits 7..0. A read with `cpu_be`=2'b01 returns 0x0000.
- R8: Pointers 0x8000..0xFFFF address the attribute RAM at index `ptr[ATTR_AW-1:0]`. Pointers 0x0000..0x7FFF address the main RAM at index `ptr[MAIN_AW-1:0]`. The two RAMs never alias each other.
- R9: A read issued before a prefetch completes returns the previous buffer contents.
- R10: While `vid_busy` is high the block issues no memory cycle. A pending store or prefetch waits and completes after `vid_busy` falls.
- R11: `cpu_rdata` is registered. It updates on the clock edge that samples a read and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Access strobe, one access per cycle it is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_reg | input | 2 | Register offset (0 pointer/buffer, 1 data, 2 stride) |
| cpu_be | input | 2 | Byte lanes: bit 1 even/upper, bit 0 odd/lower |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Registered read data |
| vid_busy | input | 1 | Video side owns the memory; CPU memory cycles wait |

## Verification
Register reads are due on the edge that samples them, so the bench drives on the falling edge and samples `cpu_rdata` one falling edge later. A pointer write refills the buffer on the (1+PF_LAT)-th edge after it is sampled, and a data write refills it one edge later still. The bench therefore waits twelve idle cycles after every table write before it reads, which covers the longest case with default parameters. For the stale-buffer case the bench reads on the very next cycle, and for the busy case it holds `vid_busy` for longer than the whole refill before it checks the old value and then the new one.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

  localparam int VA_W = 16;
  localparam int VD_W = 16;

  localparam logic [1:0] REG_PTR    = 2'd0;
  localparam logic [1:0] REG_DATA   = 2'd1;
  localparam logic [1:0] REG_STRIDE = 2'd2;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_STORE = 2'd1,
    SQ_FETCH = 2'd2
  } seq_state_t;

  // Advance inside the 15-bit half, top bit preserved.
  function automatic logic [VA_W-1:0] step_ptr(input logic [VA_W-1:0] p,
                                               input logic [VA_W-1:0] s);
    logic [VA_W-2:0] low;
    low = p[VA_W-2:0] + s[VA_W-2:0];
    return {p[VA_W-1], low};
  endfunction

endpackage

// File: rtl/vram_spram.sv
module vram_spram #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[a] <= d;
      else    q      <= mem[a];
    end
  end
endmodule

// File: rtl/vram_port_bank.sv
module vram_port_bank
  import vram_port_pkg::*;
#(
  parameter int MAIN_AW = 11,
  parameter int ATTR_AW = 11
) (
  input  logic            clk,
  input  logic            en,
  input  logic            we,
  input  logic [VA_W-1:0] addr,
  input  logic [VD_W-1:0] wdata,
  output logic [VD_W-1:0] rdata
);
  localparam int NBANK = 2;

  logic [NBANK-1:0] bank_en;
  logic [VD_W-1:0]  bank_q [NBANK];
  logic             hit_attr_q;

  assign bank_en[0] = en & ~addr[VA_W-1];
  assign bank_en[1] = en &  addr[VA_W-1];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int BAW = (b == 0) ? MAIN_AW : ATTR_AW;
    vram_spram #(.AW(BAW), .DW(VD_W)) u_ram (
      .clk (clk),
      .en  (bank_en[b]),
      .we  (we),
      .a   (addr[BAW-1:0]),
      .d   (wdata),
      .q   (bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (en && !we) hit_attr_q <= addr[VA_W-1];
  end

  assign rdata = hit_attr_q ? bank_q[1] : bank_q[0];
endmodule

// File: rtl/vram_port_seq.sv
module vram_port_seq
  import vram_port_pkg::*;
#(
  parameter int PF_LAT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vid_busy,
  input  logic            cmd_ptr,
  input  logic            cmd_data,
  input  logic            cmd_stride,
  input  logic [VD_W-1:0] cmd_val,
  input  logic [VD_W-1:0] ram_q,
  output logic [VA_W-1:0] ptr_q,
  output logic [VA_W-1:0] stride_q,
  output logic [VD_W-1:0] buf_q,
  output logic            ram_en,
  output logic            ram_we,
  output logic [VA_W-1:0] ram_addr,
  output logic [VD_W-1:0] ram_wdata,
  output logic            idle,
  output logic            storing
);
  localparam int CW = $clog2(PF_LAT) + 1;
  localparam logic [CW-1:0] LAST = CW'(PF_LAT - 1);

  seq_state_t      state;
  logic            issued;
  logic [CW-1:0]   cnt;
  logic [VD_W-1:0] wr_hold;
  logic            new_cmd;

  assign new_cmd   = cmd_ptr | cmd_data;
  assign ram_en    = !vid_busy && !new_cmd &&
                     ((state == SQ_STORE) || (state == SQ_FETCH && !issued));
  assign ram_we    = (state == SQ_STORE);
  assign ram_addr  = ptr_q;
  assign ram_wdata = wr_hold;
  assign idle      = (state == SQ_IDLE);
  assign storing   = (state == SQ_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      ptr_q    <= '0;
      stride_q <= '0;
      buf_q    <= '0;
      wr_hold  <= '0;
      issued   <= 1'b0;
      cnt      <= '0;
    end else begin
      if (cmd_stride) stride_q <= cmd_val;
      if (cmd_ptr) begin
        ptr_q  <= cmd_val;
        state  <= SQ_FETCH;
        issued <= 1'b0;
      end else if (cmd_data) begin
        wr_hold <= cmd_val;
        state   <= SQ_STORE;
        issued  <= 1'b0;
      end else begin
        unique case (state)
          SQ_STORE: begin
            if (!vid_busy) begin
              ptr_q <= step_ptr(ptr_q, stride_q);
              state <= SQ_FETCH;
            end
          end
          SQ_FETCH: begin
            if (!issued) begin
              if (!vid_busy) begin
                issued <= 1'b1;
                cnt    <= '0;
              end
            end else if (cnt == LAST) begin
              buf_q  <= ram_q;
              issued <= 1'b0;
              state  <= SQ_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vram_port.sv
module vram_port
  import vram_port_pkg::*;
#(
  parameter int MAIN_AW = 11,
  parameter int ATTR_AW = 11,
  parameter int PF_LAT  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpu_sel,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_reg,
  input  logic [1:0]  cpu_be,
  input  logic [15:0] cpu_wdata,
  output logic [15:0] cpu_rdata,
  input  logic        vid_busy
);
  localparam int HB = VD_W / 2;

  logic            wr_ok, rd_ok;
  logic [VD_W-1:0] wval, rsrc, rval;
  logic            cmd_ptr, cmd_data, cmd_stride;
  logic [VA_W-1:0] ptr_q, stride_q;
  logic [VD_W-1:0] buf_q, ram_q, ram_wdata;
  logic [VA_W-1:0] ram_addr;
  logic            ram_en, ram_we, seq_idle, seq_store;

  // Even lane must be present for a write to count; odd-only is dropped.
  assign wr_ok      = cpu_sel && cpu_we && cpu_be[1];
  assign rd_ok      = cpu_sel && !cpu_we && (cpu_be != 2'b00);
  assign wval       = cpu_be[0] ? cpu_wdata : {cpu_wdata[VD_W-1:HB], cpu_wdata[VD_W-1:HB]};
  assign cmd_ptr    = wr_ok && (cpu_reg == REG_PTR);
  assign cmd_data   = wr_ok && (cpu_reg == REG_DATA);
  assign cmd_stride = wr_ok && (cpu_reg == REG_STRIDE);

  always_comb begin
    unique case (cpu_reg)
      REG_PTR, REG_DATA: rsrc = buf_q;
      REG_STRIDE:        rsrc = stride_q;
      default:           rsrc = '0;
    endcase
    unique case (cpu_be)
      2'b11:   rval = rsrc;
      2'b10:   rval = {rsrc[VD_W-1:HB], {HB{1'b0}}};
      default: rval = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        cpu_rdata <= '0;
    else if (rd_ok) cpu_rdata <= rval;
  end

  vram_port_seq #(.PF_LAT(PF_LAT)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .vid_busy   (vid_busy),
    .cmd_ptr    (cmd_ptr),
    .cmd_data   (cmd_data),
    .cmd_stride (cmd_stride),
    .cmd_val    (wval),
    .ram_q      (ram_q),
    .ptr_q      (ptr_q),
    .stride_q   (stride_q),
    .buf_q      (buf_q),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .idle       (seq_idle),
    .storing    (seq_store)
  );

  vram_port_bank #(.MAIN_AW(MAIN_AW), .ATTR_AW(ATTR_AW)) u_bank (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_q)
  );
endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        cpu_sel,
  input logic        cpu_we,
  input logic [1:0]  cpu_be,
  input logic [15:0] cpu_rdata,
  input logic        vid_busy,
  input logic [15:0] ptr_q,
  input logic [15:0] stride_q,
  input logic [15:0] buf_q,
  input logic        ram_en,
  input logic        seq_idle,
  input logic        seq_store
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (ptr_q == 16'h0 && stride_q == 16'h0 && buf_q == 16'h0 && cpu_rdata == 16'h0));

  p_step_half_r4: assert property (@(posedge clk) disable iff (rst)
    (seq_store && ram_en) |=>
      (ptr_q[15] == $past(ptr_q[15]) &&
       ptr_q[14:0] == 15'($past(ptr_q[14:0]) + $past(stride_q[14:0]))));

  p_read_nostep_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel && !cpu_we && seq_idle) |=> $stable(ptr_q));

  p_odd_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel && cpu_we && cpu_be == 2'b01 && seq_idle) |=>
      ($stable(ptr_q) && $stable(stride_q) && seq_idle));

  p_buf_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (seq_idle && !(cpu_sel && cpu_we)) |=> $stable(buf_q));

  p_busy_defer_r10: assert property (@(posedge clk) disable iff (rst)
    vid_busy |-> !ram_en);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(cpu_sel && !cpu_we) |=> $stable(cpu_rdata));
endmodule

bind vram_port vram_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_sel   (cpu_sel),
  .cpu_we    (cpu_we),
  .cpu_be    (cpu_be),
  .cpu_rdata (cpu_rdata),
  .vid_busy  (vid_busy),
  .ptr_q     (ptr_q),
  .stride_q  (stride_q),
  .buf_q     (buf_q),
  .ram_en    (ram_en),
  .seq_idle  (seq_idle),
  .seq_store (seq_store)
);

// File: tb/vram_port_test.sv
module vram_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_sel = 1'b0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_reg = 2'd0;
  logic [1:0]  cpu_be = 2'b00;
  logic [15:0] cpu_wdata = 16'h0;
  logic [15:0] cpu_rdata;
  logic        vid_busy = 1'b0;

  int checks = 0;
  int errors = 0;

  localparam int WAITC = 12;

  always #2 clk = ~clk;

  vram_port uut (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_reg(cpu_reg),
    .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .vid_busy(vid_busy)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        rd;
    logic [1:0]  rg;
    logic [1:0]  be;
    logic [15:0] val;
  } vec_t;

  function automatic vec_t w(input logic [3:0] q, input logic [1:0] g, input logic [1:0] b,
                             input logic [15:0] v);
    return '{req: q, rd: 1'b0, rg: g, be: b, val: v};
  endfunction
  function automatic vec_t r(input logic [3:0] q, input logic [1:0] g, input logic [1:0] b,
                             input logic [15:0] e);
    return '{req: q, rd: 1'b1, rg: g, be: b, val: e};
  endfunction

  // Writes carry data, reads carry the expected value.
  localparam int NV = 54;
  localparam vec_t VEC [NV] = '{
    w(3,2,3,16'h0001), w(2,0,3,16'h0000), w(3,1,3,16'h0A0A),           // R3 stride=1
    w(8,0,3,16'h8000), w(8,1,3,16'h8080),                              // R8 attr word 0
    w(2,0,3,16'h0010), w(3,1,3,16'h1111), w(3,1,3,16'h2222),
    w(2,0,3,16'h0010), r(2,1,3,16'h1111),                              // R2 prefetch
    r(5,1,3,16'h1111), r(5,0,3,16'h1111),                              // R5 no step, mirror
    w(3,1,3,16'hABCD), r(3,1,3,16'h2222),                              // R3 step+prefetch
    w(3,0,3,16'h0010), r(3,1,3,16'hABCD), r(5,2,3,16'h0001),
    w(4,0,3,16'h7FFF), w(4,1,3,16'h3333), r(4,1,3,16'h0A0A),           // R4 low wrap
    w(4,0,3,16'hFFFF), w(4,1,3,16'h4444), r(4,1,3,16'h8080),           // R4 high wrap
    w(8,0,3,16'h8800), r(8,1,3,16'h8080),                              // R8 attr mirror
    w(8,0,3,16'h0800), r(8,1,3,16'h0A0A),                              // R8 main mirror
    w(4,2,3,16'h7FFF), r(5,2,3,16'h7FFF),
    w(4,0,3,16'h0011), w(4,1,3,16'h5555), r(4,1,3,16'hABCD),           // R4 minus one
    w(4,2,3,16'h8002), r(5,2,3,16'h8002),
    w(4,0,3,16'h000E), w(4,1,3,16'h6666), r(4,1,3,16'hABCD),           // R4 bit15 ignored
    w(6,0,2,16'h0300), w(6,1,3,16'h7777), w(6,0,3,16'h0303),
    r(6,1,3,16'h7777),                                                 // R6 byte to ptr
    w(6,1,2,16'h5A00), w(6,0,3,16'h0303), r(6,1,3,16'h5A5A),           // R6 byte data
    w(6,1,1,16'h00EE), r(6,1,3,16'h5A5A),                              // R6 odd dropped
    w(6,1,3,16'h1234), w(6,0,3,16'h0303), r(6,1,3,16'h1234),           // R6 no step
    w(6,2,1,16'h0001), r(6,2,3,16'h8002),
    r(7,2,2,16'h8000), r(7,2,1,16'h0000), r(7,1,2,16'h1200)            // R7 byte reads
  };

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] g, input logic [1:0] b, input logic [15:0] v);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_reg = g; cpu_be = b; cpu_wdata = v;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic rd_chk(input int req, input logic [1:0] g, input logic [1:0] b,
                        input logic [15:0] exp);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_reg = g; cpu_be = b;
    @(negedge clk);
    cpu_sel = 1'b0;
    chk(req, cpu_rdata, exp);
  endtask

  task automatic chk(input int req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R0 watchdog got timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(1, cpu_rdata, 16'h0000);
    rd_chk(1, 2'd1, 2'b11, 16'h0000);
    rd_chk(1, 2'd2, 2'b11, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) rd_chk(int'(VEC[i].req), VEC[i].rg, VEC[i].be, VEC[i].val);
      else begin
        wr(VEC[i].rg, VEC[i].be, VEC[i].val);
        idle(WAITC);
      end
    end

    // R9: read on the next cycle sees the old buffer, later the new one
    wr(2'd0, 2'b11, 16'h0010);
    rd_chk(9, 2'd1, 2'b11, 16'h1234);
    idle(WAITC);
    rd_chk(9, 2'd1, 2'b11, 16'hABCD);

    // R10: video busy holds off the prefetch and the store
    vid_busy = 1'b1;
    wr(2'd0, 2'b11, 16'h0303);
    idle(WAITC);
    rd_chk(10, 2'd1, 2'b11, 16'hABCD);
    vid_busy = 1'b0;
    idle(WAITC);
    rd_chk(10, 2'd1, 2'b11, 16'h1234);
    vid_busy = 1'b1;
    wr(2'd1, 2'b11, 16'hBEEF);
    idle(WAITC);
    vid_busy = 1'b0;
    idle(WAITC);
    wr(2'd0, 2'b11, 16'h0303);
    idle(WAITC);
    rd_chk(10, 2'd1, 2'b11, 16'hBEEF);

    // R11: read data holds across idle cycles
    idle(5);
    chk(11, cpu_rdata, 16'hBEEF);

    // R1: reset mid-run clears stride and buffer
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    chk(1, cpu_rdata, 16'h0000);
    rd_chk(1, 2'd2, 2'b11, 16'h0000);
    rd_chk(1, 2'd1, 2'b11, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule